// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Port

This block is a synchronous serial port with one shift register and two one-entry holding buffers, one on each side of it. Software places the next outgoing frame in the transmit holding buffer while the current frame is still shifting. Each completed incoming frame is copied to the receive holding buffer. Because the next frame is handed to the shift register on the falling clock edge that ends the current frame, frames can follow one another with an unbroken serial clock. A programmable frame width from 2 to 16 bits applies to both directions. Data is sent MSB first.

In master mode the block makes the serial clock from the system clock through a programmable divider. The clock idles low, data out changes on falling edges, and data in is sampled on rising edges. In slave mode the block follows an external serial clock with the same edge usage, after a two-flop synchronizer. If a slave frame must begin while the transmit holding buffer is empty, the block raises an underrun error. A frame that completes while the receive holding buffer is still unread replaces the old contents and raises an overrun error. An internal loopback path and a global enable complete the control set. One interrupt line reports the transmit-empty and receive-full conditions, each through its own enable.

Software reaches the registers through a valid/ready request port. `bus_ready_o` is held at 1, so the block never applies back-pressure. A request is taken on every clock edge at which `bus_valid_i` is 1. Write data and side effects act at that edge. Read data is combinational from `bus_addr_i` in the same cycle. The side effect of reading the receive buffer acts at that edge.

Top module: `sync_serial_ctrl`

## Requirements
- R1: After reset, STATUS (address 1) reads 0x01. STATUS bit 0 (transmit empty) is set when the transmit holding buffer is copied into the shift register. Writing the TX register (address 3) clears it.
- R2: `irq_o` = (STATUS bit 0 AND IEN bit 0) OR (STATUS bit 1 AND IEN bit 1), where IEN is address 2.
- R3: CTRL is address 0, with bit 0 enable, bit 1 loopback, bit 2 master, bits 7:4 width code and bits 15:8 divider D. In master mode a TX write starts `sclk_o`, which idles low and has a period of 2*(D+1) system clocks. Data goes out MSB first and changes on falling edges. `sdi_i` is sampled on rising edges.
- R4: In slave mode a frame begins when the block is enabled and again at the end of each frame. If the transmit holding buffer is empty at that point, STATUS bit 2 (transmit error) is set and the frame is sent as all zeros.
- R5: Frame width is width code + 1, with code 0 treated as 1 (2 bits). Transmit bits at or above the width are ignored. Received bits at or above it read as 0.
- R6: A completed frame is copied to the RX register (address 4, read) and STATUS bit 1 (receive full) is set. Reading RX clears bit 1.
- R7: If a frame completes while STATUS bit 1 is set and RX is not being read in that cycle, the new frame replaces RX and STATUS bit 3 (receive error) is set.
- R8: With CTRL bit 1 set, the received data is taken from the block's own serial output and `sdi_i` is ignored.
- R9: With CTRL bit 0 clear, `sclk_o` and `sdo_o` stay 0, the transmit holding buffer is not consumed, and serial clock edges receive nothing.
- R10: In master mode, a TX word written before the current frame ends follows with no gap in `sclk_o`. With an empty buffer at frame end, the clock stops low, STATUS bit 4 (busy) drops and no error is raised.
- R11: Writing 1 to STATUS bit 2 or bit 3 clears that flag. Writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid_i | input | 1 | Register request valid |
| bus_ready_o | output | 1 | Register request ready, always 1 |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, same cycle |
| sclk_o | output | 1 | Serial clock out (master) |
| sclk_i | input | 1 | Serial clock in (slave) |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: a 16-bit maximum frame and an 8-bit divider. Every width code from the clamped 2-bit case up to the full 16 bits can therefore be reached. Upper transmit bits can be set and then shown to vanish. Divider values of 0, 1 and 2 are set at run time, which keeps frames short. They also make the period of the generated clock measurable in whole system cycles, as does the gap-free handoff between two frames.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int ADDR_W = 3;
  localparam int BUS_W  = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 3'd0,
    REG_STAT = 3'd1,
    REG_IEN  = 3'd2,
    REG_TX   = 3'd3,
    REG_RX   = 3'd4
  } reg_addr_e;

  // control field positions
  localparam int C_EN   = 0;
  localparam int C_LOOP = 1;
  localparam int C_MAST = 2;
  localparam int C_WC   = 4;
  localparam int C_DIV  = 8;

  // status bit positions
  localparam int S_TXE  = 0;
  localparam int S_RXF  = 1;
  localparam int S_TERR = 2;
  localparam int S_RERR = 3;
  localparam int S_BUSY = 4;
endpackage

// File: rtl/ssc_clkgen.sv
module ssc_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt;
  logic             sclk_q;
  logic             tick;

  assign tick = run && (cnt == div);
  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;
  assign sclk = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && $past(!run)) |-> !sclk_q); // R3
endmodule

// File: rtl/ssc_edge_sync.sv
module ssc_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '0;
    else        sy <= {sy[1:0], pin};
  end

  assign rise = sy[1] && !sy[2];
  assign fall = !sy[1] && sy[2];
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
  parameter int FRAME_MAX = 16,
  localparam int WC_W = $clog2(FRAME_MAX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 load,
  input  logic [FRAME_MAX-1:0] load_word,
  input  logic                 rise,
  input  logic                 fall,
  input  logic [WC_W-1:0]      wlast,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 rx_done,
  output logic [FRAME_MAX-1:0] rx_word,
  output logic                 frame_end
);
  logic [FRAME_MAX-1:0] sh;
  logic [FRAME_MAX-1:0] mask;
  logic [WC_W-1:0]      bitcnt;
  logic                 in_bit;
  logic                 last_pend;

  for (genvar i = 0; i < FRAME_MAX; i++) begin : g_mask
    assign mask[i] = (WC_W'(i) <= wlast);
  end

  assign sdo       = sh[wlast];
  assign rx_done   = rise && (bitcnt == wlast);
  assign rx_word   = {sh[FRAME_MAX-2:0], sdi} & mask;
  assign frame_end = fall && last_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh        <= '0;
      bitcnt    <= '0;
      in_bit    <= 1'b0;
      last_pend <= 1'b0;
    end else if (clr) begin
      sh        <= '0;
      bitcnt    <= '0;
      in_bit    <= 1'b0;
      last_pend <= 1'b0;
    end else if (load) begin
      sh        <= load_word & mask;
      bitcnt    <= '0;
      last_pend <= 1'b0;
    end else if (rise) begin
      in_bit    <= sdi;
      bitcnt    <= rx_done ? '0 : bitcnt + 1'b1;
      last_pend <= rx_done;
    end else if (fall) begin
      sh        <= {sh[FRAME_MAX-2:0], in_bit};
      last_pend <= 1'b0;
    end
  end

  AST_LOAD_RESTARTS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> !frame_end); // R10
endmodule

// File: rtl/sync_serial_ctrl.sv
module sync_serial_ctrl
  import ssc_pkg::*;
#(
  parameter int FRAME_MAX = 16,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid_i,
  output logic              bus_ready_o,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              sclk_o,
  input  logic              sclk_i,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              irq_o
);
  localparam int WC_W = $clog2(FRAME_MAX);

  // control and status state
  logic                 ctrl_en, ctrl_loop, ctrl_master;
  logic [WC_W-1:0]      ctrl_wcode;
  logic [DIV_W-1:0]     ctrl_div;
  logic                 ien_tx, ien_rx;
  logic [FRAME_MAX-1:0] txbuf, rxbuf;
  logic                 tx_empty, rx_full, tx_err, rx_err, active;

  // request decode
  logic wr, rd, wr_ctrl, wr_stat, wr_ien, wr_tx, rd_rx;
  assign bus_ready_o = 1'b1;
  assign wr      = bus_valid_i && bus_write_i;
  assign rd      = bus_valid_i && !bus_write_i;
  assign wr_ctrl = wr && (bus_addr_i == REG_CTRL);
  assign wr_stat = wr && (bus_addr_i == REG_STAT);
  assign wr_ien  = wr && (bus_addr_i == REG_IEN);
  assign wr_tx   = wr && (bus_addr_i == REG_TX);
  assign rd_rx   = rd && (bus_addr_i == REG_RX);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata_i[BUS_W-1:C_DIV+DIV_W], bus_wdata_i[3]};

  // serial datapath
  logic [WC_W-1:0]      wlast;
  logic                 run, m_sclk, m_rise, m_fall, s_rise, s_fall;
  logic                 rise_ev, fall_ev, sdo_int, sdi_int;
  logic                 rx_done, frame_end;
  logic [FRAME_MAX-1:0] rx_word;
  logic                 m_start, m_stop, s_start, load_ev, take_buf, underrun;

  assign wlast   = (ctrl_wcode == '0) ? WC_W'(1) : ctrl_wcode;
  assign run     = ctrl_en && ctrl_master && active;
  assign rise_ev = ctrl_en && active && (ctrl_master ? m_rise : s_rise);
  assign fall_ev = ctrl_en && active && (ctrl_master ? m_fall : s_fall);
  assign sdi_int = ctrl_loop ? sdo_int : sdi_i;

  ssc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(run), .div(ctrl_div),
    .sclk(m_sclk), .rise(m_rise), .fall(m_fall)
  );

  ssc_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .pin(sclk_i), .rise(s_rise), .fall(s_fall)
  );

  ssc_shifter #(.FRAME_MAX(FRAME_MAX)) u_shifter (
    .clk(clk), .rst_n(rst_n), .clr(!ctrl_en), .load(load_ev),
    .load_word(take_buf ? txbuf : '0), .rise(rise_ev), .fall(fall_ev),
    .wlast(wlast), .sdi(sdi_int), .sdo(sdo_int), .rx_done(rx_done),
    .rx_word(rx_word), .frame_end(frame_end)
  );

  // frame sequencing
  assign m_start  = ctrl_en && ctrl_master && !tx_empty && (!active || frame_end);
  assign m_stop   = ctrl_en && ctrl_master && frame_end && tx_empty;
  assign s_start  = ctrl_en && !ctrl_master && (!active || frame_end);
  assign load_ev  = m_start || s_start;
  assign take_buf = load_ev && !tx_empty;
  assign underrun = s_start && tx_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en     <= 1'b0;
      ctrl_loop   <= 1'b0;
      ctrl_master <= 1'b0;
      ctrl_wcode  <= '0;
      ctrl_div    <= '0;
      ien_tx      <= 1'b0;
      ien_rx      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en     <= bus_wdata_i[C_EN];
        ctrl_loop   <= bus_wdata_i[C_LOOP];
        ctrl_master <= bus_wdata_i[C_MAST];
        ctrl_wcode  <= bus_wdata_i[C_WC +: WC_W];
        ctrl_div    <= bus_wdata_i[C_DIV +: DIV_W];
      end
      if (wr_ien) begin
        ien_tx <= bus_wdata_i[0];
        ien_rx <= bus_wdata_i[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txbuf    <= '0;
      tx_empty <= 1'b1;
      tx_err   <= 1'b0;
      active   <= 1'b0;
    end else begin
      if (wr_tx) txbuf <= bus_wdata_i[FRAME_MAX-1:0];
      if (wr_tx)         tx_empty <= 1'b0;
      else if (take_buf) tx_empty <= 1'b1;
      if (underrun)                          tx_err <= 1'b1;
      else if (wr_stat && bus_wdata_i[S_TERR]) tx_err <= 1'b0;
      if (!ctrl_en)     active <= 1'b0;
      else if (load_ev) active <= 1'b1;
      else if (m_stop)  active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf   <= '0;
      rx_full <= 1'b0;
      rx_err  <= 1'b0;
    end else begin
      if (rx_done) rxbuf <= rx_word;
      if (rx_done)    rx_full <= 1'b1;
      else if (rd_rx) rx_full <= 1'b0;
      if (rx_done && rx_full && !rd_rx)        rx_err <= 1'b1;
      else if (wr_stat && bus_wdata_i[S_RERR]) rx_err <= 1'b0;
    end
  end

  // outputs
  assign sclk_o = m_sclk;
  assign sdo_o  = ctrl_en && sdo_int;
  assign irq_o  = (tx_empty && ien_tx) || (rx_full && ien_rx);

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_CTRL: begin
        bus_rdata_o[C_EN]              = ctrl_en;
        bus_rdata_o[C_LOOP]            = ctrl_loop;
        bus_rdata_o[C_MAST]            = ctrl_master;
        bus_rdata_o[C_WC +: WC_W]      = ctrl_wcode;
        bus_rdata_o[C_DIV +: DIV_W]    = ctrl_div;
      end
      REG_STAT: begin
        bus_rdata_o[S_TXE]  = tx_empty;
        bus_rdata_o[S_RXF]  = rx_full;
        bus_rdata_o[S_TERR] = tx_err;
        bus_rdata_o[S_RERR] = rx_err;
        bus_rdata_o[S_BUSY] = active;
      end
      REG_IEN: begin
        bus_rdata_o[0] = ien_tx;
        bus_rdata_o[1] = ien_rx;
      end
      REG_TX:  bus_rdata_o[FRAME_MAX-1:0] = txbuf;
      REG_RX:  bus_rdata_o[FRAME_MAX-1:0] = rxbuf;
      default: bus_rdata_o = '0;
    endcase
  end

  AST_TXE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (take_buf && !wr_tx) |=> tx_empty); // R1
  AST_TXE_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !tx_empty); // R1
  AST_RXF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_full); // R6
  AST_RX_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && rx_full && !rd_rx) |=> (rx_err && rxbuf == $past(rx_word))); // R7
  AST_SLAVE_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && !ctrl_master && frame_end && tx_empty && !wr_tx) |=> tx_err); // R4
  AST_MASTER_NO_TXERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && ctrl_master) |=> !$rose(tx_err)); // R10
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> !active); // R9
endmodule

// File: tb/sync_serial_ctrl_bench.sv
module sync_serial_ctrl_bench;
  localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_IEN = 3'd2,
                         A_TX = 3'd3, A_RX = 3'd4;
  localparam int NV = 7;
  // {width code, TX word, expected RX word}: R5 width and masking, R8 loopback
  localparam logic [35:0] VEC [NV] = '{
    {4'd15, 16'hA5C3, 16'hA5C3},
    {4'd7,  16'h12F0, 16'h00F0},
    {4'd3,  16'hFFF9, 16'h0009},
    {4'd1,  16'h0002, 16'h0002},
    {4'd0,  16'h0007, 16'h0003},
    {4'd11, 16'h8001, 16'h0001},
    {4'd10, 16'h07FF, 16'h07FF}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_ready, sclk_o, sdo_o, irq_o;
  logic        sclk_i = 1'b0, sdi_i = 1'b0;

  int total = 0, fails = 0;
  int n_rise = 0;
  time rise_t [256];
  logic [31:0] cap = '0;

  always #4 clk = ~clk;

  sync_serial_ctrl u_sync_serial_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid_i(bus_valid), .bus_ready_o(bus_ready),
    .bus_write_i(bus_write), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .sclk_o(sclk_o), .sclk_i(sclk_i), .sdo_o(sdo_o),
    .sdi_i(sdi_i), .irq_o(irq_o)
  );

  always @(posedge sclk_o) begin
    if (n_rise < 256) rise_t[n_rise] = $time;
    n_rise = n_rise + 1;
    cap = {cap[30:0], sdo_o};
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 2000; k++) begin
      bus_rd(A_STAT, s);
      if (!s[4]) break;
    end
  endtask

  task automatic wait_rx();
    logic [31:0] s;
    for (int k = 0; k < 2000; k++) begin
      bus_rd(A_STAT, s);
      if (s[1]) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total + 1);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  sbits;
    logic [3:0]  spat [2];
    int base;
    spat[0] = 4'h9; spat[1] = 4'h6;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("reset sclk_o", {31'd0, sclk_o}, 32'd0);
    check("reset sdo_o", {31'd0, sdo_o}, 32'd0);
    check("reset irq_o", {31'd0, irq_o}, 32'd0);
    bus_rd(A_STAT, r);
    check("R1 reset status", r, 32'h01);

    // R2 transmit-empty interrupt
    bus_wr(A_IEN, 32'h1);
    @(negedge clk);
    check("R2 irq tx empty enabled", {31'd0, irq_o}, 32'd1);
    bus_wr(A_IEN, 32'h0);
    @(negedge clk);
    check("R2 irq masked", {31'd0, irq_o}, 32'd0);

    // vector table: loopback master frames across widths (R5, R8, R6)
    for (int v = 0; v < NV; v++) begin
      bus_wr(A_CTRL, 32'h107 | ({28'd0, VEC[v][35:32]} << 4));
      bus_wr(A_TX, {16'd0, VEC[v][31:16]});
      wait_rx();
      bus_rd(A_RX, r);
      check("R5 R8 loopback rx word", r, {16'd0, VEC[v][15:0]});
      bus_rd(A_STAT, r);
      check("R6 rx full cleared by read", r & 32'h0E, 32'h0);
    end

    // R2 receive-full interrupt
    bus_wr(A_IEN, 32'h2);
    bus_wr(A_TX, 32'h3C);
    wait_rx();
    @(negedge clk);
    check("R2 irq rx full", {31'd0, irq_o}, 32'd1);
    bus_rd(A_RX, r);
    @(negedge clk);
    check("R2 irq after rx read", {31'd0, irq_o}, 32'd0);
    bus_wr(A_IEN, 32'h0);

    // R3 master, external data, divider 2
    bus_wr(A_CTRL, 32'h275);
    base = n_rise;
    sdi_i = 1'b0;
    bus_wr(A_TX, 32'hA5);
    for (int b = 6; b >= 0; b--) begin
      @(negedge sclk_o);
      sdi_i = b[1] ^ b[0] ? 1'b1 : 1'b0;
    end
    wait_idle();
    check("R3 msb first out", cap & 32'hFF, 32'hA5);
    check("R3 rising edge count", n_rise - base, 8);
    check("R3 clock period", 32'(rise_t[base+1] - rise_t[base]), 32'd48);
    bus_rd(A_RX, r);
    // sdi pattern over bits 7..0: 0,1,1,0,0,1,1,0 = 0x66
    check("R3 rx sampled on rise", r, 32'h66);
    check("R3 clock idles low", {31'd0, sclk_o}, 32'd0);

    // R10 gapless handoff with loopback, also R7 overwrite and R11 clear
    bus_wr(A_CTRL, 32'h037);
    base = n_rise;
    bus_wr(A_TX, 32'h9);
    @(negedge clk);
    bus_wr(A_TX, 32'h6);
    for (int k = 0; k < 2000 && n_rise < base + 8; k++) @(negedge clk);
    wait_idle();
    check("R10 two frames of rises", n_rise - base, 8);
    check("R10 no gap at handoff", 32'(rise_t[base+4] - rise_t[base+3]), 32'd16);
    check("R10 back to back bits", cap & 32'hFF, 32'h96);
    bus_rd(A_STAT, r);
    check("R7 R10 status after overwrite", r, 32'h0B);
    bus_rd(A_RX, r);
    check("R7 newest frame kept", r, 32'h6);
    bus_wr(A_STAT, 32'h8);
    bus_rd(A_STAT, r);
    check("R11 rx error cleared", r, 32'h01);

    // R4 slave underrun
    bus_wr(A_CTRL, 32'h0);
    bus_wr(A_TX, 32'hC);
    bus_wr(A_CTRL, 32'h31);
    repeat (4) @(negedge clk);
    sbits = '0;
    for (int f = 0; f < 2; f++) begin
      for (int b = 3; b >= 0; b--) begin
        sdi_i = spat[f][b];
        repeat (5) @(negedge clk);
        sbits = {sbits[6:0], sdo_o};
        sclk_i = 1'b1;
        repeat (5) @(negedge clk);
        sclk_i = 1'b0;
      end
    end
    repeat (6) @(negedge clk);
    check("R4 slave frame then zeros", {24'd0, sbits}, 32'hC0);
    bus_rd(A_STAT, r);
    check("R4 R7 slave status", r, 32'h1F);
    bus_rd(A_RX, r);
    check("R7 slave overwrite data", r, 32'h6);
    bus_wr(A_STAT, 32'h0C);
    bus_rd(A_STAT, r);
    check("R11 both errors cleared", r, 32'h11);
    bus_wr(A_CTRL, 32'h0);

    // R9 disabled block
    bus_wr(A_CTRL, 32'h74);
    base = n_rise;
    bus_wr(A_TX, 32'h55);
    repeat (40) @(negedge clk);
    check("R9 no clock when disabled", n_rise - base, 0);
    check("R9 sdo quiet", {31'd0, sdo_o}, 32'd0);
    bus_wr(A_CTRL, 32'h10);
    sdi_i = 1'b1;
    for (int k = 0; k < 4; k++) begin
      repeat (5) @(negedge clk); sclk_i = 1'b1;
      repeat (5) @(negedge clk); sclk_i = 1'b0;
    end
    repeat (6) @(negedge clk);
    bus_rd(A_STAT, r);
    check("R9 buffer kept, nothing received", r, 32'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule